// File: doc/BRIEF.md
# Double-Buffered Fiducial Event Sequencer

This block is the sending end of a timing event system. It holds two sequence banks. Each entry in a bank has an 8-bit event code and a tick offset, counted from the fiducial. When a fiducial strobe arrives, the active bank is played out: every entry's code goes onto the event output in the tick its offset comes due. Every other tick carries the null code 0. One tick is one clock cycle.

When a playout finishes, the two banks swap roles. The bank that was loaded in advance becomes active for the next fiducial. The bank that has just been played becomes writable again. As a result, software always loads the sequence for the fiducial after next. Writes aimed at the bank that is currently active are refused and flagged.

A fiducial that arrives while a playout is still running cuts that playout short. The swap is forced and a sticky overrun flag is set. The new fiducial then plays out the bank that has just become active.

Top module: `fid_event_seq`

## Requirements
- R1: When `fid_i` is sampled high at a clock edge E0, playout of the active bank starts at entry 0. An entry with offset k whose code is nonzero appears on `evt_code_o` during the cycle after edge E0+k+1. A fiducial that arrives with no playout running does not swap banks.
- R2: `evt_code_o` is 0 on every tick where no entry fires, and also whenever no playout is running.
- R3: If an entry's offset is less than or equal to the tick in which the previous entry was emitted, that entry is emitted on the next tick. No entry is lost.
- R4: A playout ends at the first entry whose code is 0. In the cycle after the ending edge, `done_o` is high for one cycle and `active_bank_o` has toggled. A bank holding code 0 in entry 0 ends its playout at once.
- R5: A playout also ends once entry DEPTH-1 has been emitted, with the same `done_o` pulse and bank toggle as in R4. No entry past DEPTH-1 is read.
- R6: A fiducial that arrives during a playout that is not ending in that cycle has these effects:
  - it aborts the playout;
  - it toggles `active_bank_o`;
  - it sets the sticky flag `overrun_o`;
  - it gives no `done_o` pulse;
  - it starts playout of the newly active bank, so that bank's offset-0 entry appears one cycle after the following edge.
- R7: A write with `wr_bank_i` equal to `active_bank_o` does not change the bank's contents. It sets the sticky flag `wr_err_o`.
- R8: A write to the inactive bank stores the code and offset at `wr_addr_i`. That entry then plays out in a later playout.
- R9: After reset the following hold:
  - bank 0 is active;
  - every entry of both banks holds code 0;
  - `evt_code_o` is 0;
  - `done_o`, `overrun_o` and `wr_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fid_i | input | 1 | Fiducial strobe, one cycle wide |
| wr_en_i | input | 1 | Sequence entry write enable |
| wr_bank_i | input | 1 | Bank that the write targets |
| wr_addr_i | input | $clog2(DEPTH) | Entry index of the write |
| wr_code_i | input | 8 | Event code to store (0 ends the sequence) |
| wr_ofs_i | input | OFS_W | Tick offset from the fiducial |
| evt_code_o | output | 8 | Event code for this tick, 0 when idle |
| active_bank_o | output | 1 | Bank played on the next or current fiducial |
| done_o | output | 1 | One-cycle pulse when a playout completes normally |
| overrun_o | output | 1 | Sticky: a fiducial cut a playout short |
| wr_err_o | output | 1 | Sticky: a write targeted the active bank |

## Verification
The main playout is driven with four sequences, each aimed at a different behaviour:
- An empty bank that received only a refused write. This separates rejection from storage and shows that an empty playout finishes immediately.
- A sparse sequence with a duplicated offset. This checks exact emission ticks, idle zeros and the one-tick slip on a collision.
- A bank with every entry filled. This shows that playout stops at the last entry even without a terminator.
- A replay that is interrupted by an early fiducial. This separates a forced swap from a normal completion: the overrun flag is set, no done pulse occurs, and the next bank starts cleanly.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t NULL_CODE = '0;
endpackage

// File: rtl/fes_bank.sv
module fes_bank
  import fes_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int OFS_W = 20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  code_t            wcode,
  input  logic [OFS_W-1:0] wofs,
  input  logic [AW-1:0]    raddr,
  output code_t            rcode,
  output logic [OFS_W-1:0] rofs
);
  code_t            code_mem [DEPTH];
  logic [OFS_W-1:0] ofs_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        code_mem[i] <= NULL_CODE;
        ofs_mem[i]  <= '0;
      end
    end else if (we) begin
      code_mem[waddr] <= wcode;
      ofs_mem[waddr]  <= wofs;
    end
  end

  assign rcode = code_mem[raddr];
  assign rofs  = ofs_mem[raddr];
endmodule

// File: rtl/fes_pingpong.sv
module fes_pingpong (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swap,
  input  logic       wr_en,
  input  logic       wr_bank,
  output logic       active,
  output logic [1:0] bank_we,
  output logic       wr_err
);
  logic reject_w;

  assign reject_w = wr_en && (wr_bank == active);

  always_comb begin
    bank_we = 2'b00;
    if (wr_en && !reject_w) bank_we[wr_bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      if (swap) active <= ~active;
      if (reject_w) wr_err <= 1'b1;
    end
  end
endmodule

// File: rtl/fes_player.sv
module fes_player
  import fes_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int OFS_W = 20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fid,
  input  code_t            rcode,
  input  logic [OFS_W-1:0] rofs,
  output logic [AW-1:0]    raddr,
  output code_t            evt_code,
  output logic             done,
  output logic             overrun,
  output logic             swap,
  output logic             busy,
  output logic             fire,
  output logic             finish
);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
  localparam logic [OFS_W-1:0] TICK_MAX = '1;

  logic [OFS_W-1:0] tcnt;
  logic             abort_w;

  function automatic logic entry_due(code_t c, logic [OFS_W-1:0] ofs,
                                     logic [OFS_W-1:0] now);
    return (c != NULL_CODE) && (now >= ofs);
  endfunction

  function automatic logic at_last(logic [AW-1:0] i);
    return i == LAST_IDX;
  endfunction

  assign fire    = busy && entry_due(rcode, rofs, tcnt);
  assign finish  = busy && ((rcode == NULL_CODE) || (fire && at_last(raddr)));
  assign abort_w = busy && fid && !finish;
  assign swap    = finish || abort_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      raddr    <= '0;
      tcnt     <= '0;
      evt_code <= NULL_CODE;
      done     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      evt_code <= fire ? rcode : NULL_CODE;
      done     <= finish;
      if (abort_w) overrun <= 1'b1;
      if (fid) begin
        busy  <= 1'b1;
        raddr <= '0;
        tcnt  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (tcnt != TICK_MAX) tcnt <= tcnt + 1'b1;
        if (fire) raddr <= raddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fid_event_seq.sv
module fid_event_seq
  import fes_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int OFS_W = 20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fid_i,
  input  logic             wr_en_i,
  input  logic             wr_bank_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [7:0]       wr_code_i,
  input  logic [OFS_W-1:0] wr_ofs_i,
  output logic [7:0]       evt_code_o,
  output logic             active_bank_o,
  output logic             done_o,
  output logic             overrun_o,
  output logic             wr_err_o
);
  logic [1:0]       bank_we;
  logic [AW-1:0]    rd_idx;
  code_t            bk_code [2];
  logic [OFS_W-1:0] bk_ofs  [2];
  code_t            cur_code;
  logic [OFS_W-1:0] cur_ofs;
  logic             swap_w, busy_w, fire_w, finish_w;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    fes_bank #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_we[g]),
      .waddr(wr_addr_i), .wcode(wr_code_i), .wofs(wr_ofs_i),
      .raddr(rd_idx), .rcode(bk_code[g]), .rofs(bk_ofs[g])
    );
  end

  assign cur_code = bk_code[active_bank_o];
  assign cur_ofs  = bk_ofs[active_bank_o];

  fes_pingpong u_pp (
    .clk(clk), .rst_n(rst_n), .swap(swap_w),
    .wr_en(wr_en_i), .wr_bank(wr_bank_i),
    .active(active_bank_o), .bank_we(bank_we), .wr_err(wr_err_o)
  );

  fes_player #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_play (
    .clk(clk), .rst_n(rst_n), .fid(fid_i),
    .rcode(cur_code), .rofs(cur_ofs), .raddr(rd_idx),
    .evt_code(evt_code_o), .done(done_o), .overrun(overrun_o),
    .swap(swap_w), .busy(busy_w), .fire(fire_w), .finish(finish_w)
  );
endmodule

// File: rtl/fid_event_seq_chk.sv
module fid_event_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fid_i,
  input logic       wr_en_i,
  input logic       wr_bank_i,
  input logic [7:0] evt_code_o,
  input logic       active_bank_o,
  input logic       done_o,
  input logic       overrun_o,
  input logic       wr_err_o,
  input logic       busy,
  input logic       fire,
  input logic       finish,
  input logic       swap
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> evt_code_o == 8'd0);
  // R2
  idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fire);
  // R4
  done_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_o && (active_bank_o != $past(active_bank_o)));
  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(active_bank_o));
  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  // R6
  abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fid_i && !finish) |=> overrun_o && !done_o);
  // R7
  wr_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |=> wr_err_o);
  // R7
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_bank_i == active_bank_o)) |=> wr_err_o);
endmodule

bind fid_event_seq fid_event_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fid_i(fid_i), .wr_en_i(wr_en_i),
  .wr_bank_i(wr_bank_i), .evt_code_o(evt_code_o),
  .active_bank_o(active_bank_o), .done_o(done_o), .overrun_o(overrun_o),
  .wr_err_o(wr_err_o), .busy(busy_w), .fire(fire_w), .finish(finish_w),
  .swap(swap_w)
);

// File: tb/fid_event_seq_test.sv
`timescale 1ns/1ps
module fid_event_seq_test;
  localparam int DEPTH = 8;
  localparam int OFS_W = 20;
  localparam int AW = $clog2(DEPTH);
  // stimulus: code, offset; expected emission tick
  localparam int NV = 4;
  localparam int V_CODE [NV] = '{5, 7, 8, 9};
  localparam int V_OFS  [NV] = '{2, 4, 4, 10};
  localparam int V_TICK [NV] = '{2, 4, 5, 10};

  logic clk = 0, rst_n = 0, fid = 0, wr_en = 0, wr_bank = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_code = '0;
  logic [OFS_W-1:0] wr_ofs = '0;
  logic [7:0] evt;
  logic active, done, overrun, wr_err;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  fid_event_seq #(.DEPTH(DEPTH), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst_n(rst_n), .fid_i(fid), .wr_en_i(wr_en),
    .wr_bank_i(wr_bank), .wr_addr_i(wr_addr), .wr_code_i(wr_code),
    .wr_ofs_i(wr_ofs), .evt_code_o(evt), .active_bank_o(active),
    .done_o(done), .overrun_o(overrun), .wr_err_o(wr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic b, input int a, input int c, input int o);
    @(negedge clk);
    wr_en = 1; wr_bank = b; wr_addr = AW'(a); wr_code = 8'(c); wr_ofs = OFS_W'(o);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_fid;
    @(negedge clk); fid = 1;
    @(negedge clk); fid = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 evt", evt, 0);
    chk("R9 active", active, 0);
    chk("R9 done", done, 0);
    chk("R9 overrun", overrun, 0);
    chk("R9 wr_err", wr_err, 0);

    // R8 load bank 1 from the vector table, terminator after
    for (int i = 0; i < NV; i++) wr(1'b1, i, V_CODE[i], V_OFS[i]);
    wr(1'b1, NV, 0, 0);
    chk("R8 accepted write no error", wr_err, 0);

    // R7 write to active bank 0 is refused
    wr(1'b0, 0, 9, 0);
    chk("R7 wr_err set", wr_err, 1);

    // fiducial 1: bank 0 (reset-empty, refused write) plays nothing
    pulse_fid();
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      chk("R7 refused entry not emitted", evt, 0);
      chk("R4 empty bank done", done, (j == 1) ? 1 : 0);
    end
    chk("R4 swap to bank 1", active, 1);

    // R8 fill every entry of bank 0 (no terminator)
    for (int i = 0; i < DEPTH; i++) wr(1'b0, i, 16 + i, 2 * i);

    // fiducial 2: play bank 1 from the table
    pulse_fid();
    for (int j = 1; j <= 16; j++) begin
      int exp_c;
      @(negedge clk);
      exp_c = 0;
      for (int i = 0; i < NV; i++) if (V_TICK[i] == j - 1) exp_c = V_CODE[i];
      if (j == 6) chk("R3 same-offset slips one tick", evt, exp_c);
      else        chk("R1 R2 table playout", evt, exp_c);
      chk("R4 done after terminator", done, (j == 12) ? 1 : 0);
    end
    chk("R4 swap to bank 0", active, 0);
    chk("R6 no overrun yet", overrun, 0);

    // fiducial 3: full bank 0, stops after last entry
    pulse_fid();
    for (int j = 1; j <= 18; j++) begin
      @(negedge clk);
      chk("R5 full bank playout", evt,
          (j % 2 == 1 && j <= 2 * DEPTH - 1) ? 16 + (j - 1) / 2 : 0);
      chk("R5 done after last entry", done, (j == 2 * DEPTH - 1) ? 1 : 0);
    end
    chk("R5 swap to bank 1", active, 1);

    // fiducial 4 then early fiducial 5: overrun
    pulse_fid();
    for (int j = 1; j <= 5; j++) @(negedge clk);
    fid = 1;
    @(negedge clk);
    fid = 0;
    chk("R6 overrun set", overrun, 1);
    chk("R6 forced swap", active, 0);
    chk("R6 no done on abort", done, 0);
    @(negedge clk);
    chk("R6 new bank first event", evt, 16);
    repeat (20) @(negedge clk);
    chk("R6 overrun sticky", overrun, 1);
    chk("R1 new bank completes and swaps", active, 1);
    chk("R2 idle output zero", evt, 0);

    // R1 fiducial when idle does not swap before playout
    pulse_fid();
    chk("R1 idle fiducial no swap", active, 1);
    repeat (15) @(negedge clk);
    summary();
  end
endmodule